// File: doc/BRIEF.md
# Gate-Grid Netlist Fitness Scorer

This block scores a tiny encoded logic network against a required truth table. The network is described by seven gate rows. Each row holds three 4-bit codes: a first operand, a gate type and a second operand. The first three rows drive the first-column nets R0..R2, the next three drive the second-column nets S0..S2, and the last row drives the network output F. The network has three primary inputs, A, B and C.

After a netlist and an 8-bit target column are loaded, a start pulse makes the block step through the eight input combinations, one per clock. It counts how many of them give an F equal to the target bit. The count, from 0 to 8, is presented as the fitness with a done flag. An outer search loop can then score candidate netlists one after another.

Top module: `gate_grid_fitness`

## Requirements
- R1: While reset is held and after its release, `done` is 0 and `fitness` is 0 until the first sweep ends.
- R2: Operand code 1 selects A, 2 selects B, 3 selects C, 4/5/6 select R0/R1/R2 and 7/8/9 select S0/S1/S2. For combination k, A is bit 2 of k, B is bit 1 and C is bit 0.
- R3: Gate code 1 is AND, 2 is OR and 3 is XOR of the two operands. Code 4 is NOT of the first operand only. Code 0 and codes 5..15 give logic 0.
- R4: An operand of code 0, a code of 10..15, or a code naming a net that is not produced by an earlier row (including the row's own net) reads as logic 0.
- R5: The fitness is the number of combinations k in 0..7 for which F equals bit k of the target, so it never exceeds 8.
- R6: If `start` is sampled on clock edge E0, then `done` is 0 after edges E1..E7 and rises with a valid `fitness` after edge E8. Both hold until the next accepted start.
- R7: A `start` pulse during a sweep is ignored: the sweep ends on its original schedule with its original result.
- R8: `load` captures the codes and the target only while no sweep is running. A load during a sweep is ignored, and the codes already held stay in use.
- R9: Row index r (0..6) occupies code slots 3r (first operand), 3r+1 (gate) and 3r+2 (second operand). Slot i sits at bits [4i+3:4i] of `codes_in`. Rows 0..2 drive R0..R2, rows 3..5 drive S0..S2 and row 6 drives F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture `codes_in` and `target_in` when idle |
| codes_in | input | 84 | Twenty-one packed 4-bit codes, slot i at bits [4i+3:4i] |
| target_in | input | 8 | Required output, bit k for combination k |
| start | input | 1 | Begin a sweep when idle |
| done | output | 1 | Sweep result valid |
| fitness | output | 4 | Number of matching combinations, 0..8 |

## Verification
The fitness is due eight edges after the edge that samples `start`. The bench raises `start` on a falling edge, then samples `done` on each of the next eight falling edges. It expects 0 on the first seven and 1 on the eighth, and it reads `fitness` only on that eighth falling edge. For mid-sweep `start` and `load` pulses, the bench injects them on the falling edge after the third evaluation edge and expects the unchanged schedule and result. Expected fitness values come from a behavioural netlist interpreter in the bench, used over directed netlists and a few hundred pseudo-random ones.

// File: rtl/gg_pkg.sv
package gg_pkg;
  localparam int CODE_W  = 4;
  localparam int ROWS    = 7;
  localparam int SLOTS   = 3;
  localparam int N_PI    = 3;
  localparam int NCOMBO  = 1 << N_PI;
  localparam int NET_N   = 1 + N_PI + ROWS - 1;   // null + inputs + internal nets
  localparam int CODES_W = ROWS * SLOTS * CODE_W;
  localparam int IDX_W   = $clog2(NCOMBO);
  localparam int FIT_W   = $clog2(NCOMBO + 1);

  typedef enum logic [CODE_W-1:0] {
    G_NONE = 4'd0,
    G_AND  = 4'd1,
    G_OR   = 4'd2,
    G_XOR  = 4'd3,
    G_NOT  = 4'd4
  } gate_e;

  // Value of an operand code at row r; out-of-order or illegal codes read 0.
  function automatic logic operand_val(input logic [CODE_W-1:0] code,
                                       input int row,
                                       input logic [NET_N-1:0] nets);
    int c;
    c = int'(code);
    if (c >= 1 && c < NET_N && c < (N_PI + 1 + row))
      return nets[c];
    return 1'b0;
  endfunction

  function automatic logic gate_val(input logic [CODE_W-1:0] g,
                                    input logic x, input logic y);
    case (g)
      G_AND:   return x & y;
      G_OR:    return x | y;
      G_XOR:   return x ^ y;
      G_NOT:   return ~x;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] slot(input logic [CODES_W-1:0] codes,
                                             input int idx);
    return codes[idx*CODE_W +: CODE_W];
  endfunction

  // Evaluate the whole network for one input combination.
  function automatic logic net_output(input logic [CODES_W-1:0] codes,
                                      input logic [IDX_W-1:0] combo);
    logic [NET_N-1:0] nets;
    logic y;
    nets = '0;
    for (int i = 0; i < N_PI; i++)
      nets[1 + i] = combo[N_PI - 1 - i];
    y = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      y = gate_val(slot(codes, r*SLOTS + 1),
                   operand_val(slot(codes, r*SLOTS), r, nets),
                   operand_val(slot(codes, r*SLOTS + 2), r, nets));
      if (r < ROWS - 1)
        nets[N_PI + 1 + r] = y;
    end
    return y;
  endfunction
endpackage

// File: rtl/gg_code_store.sv
module gg_code_store
  import gg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               busy,
  input  logic [CODES_W-1:0] codes_in,
  input  logic [NCOMBO-1:0]  target_in,
  output logic [CODES_W-1:0] codes_q,
  output logic [NCOMBO-1:0]  target_q
);
  logic take;
  assign take = load && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codes_q  <= '0;
      target_q <= '0;
    end else if (take) begin
      codes_q  <= codes_in;
      target_q <= target_in;
    end
  end

  // R8: nothing captured while a sweep runs
  assert_load_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(codes_q) && $stable(target_q)));
endmodule

// File: rtl/gg_net_eval.sv
module gg_net_eval
  import gg_pkg::*;
(
  input  logic [CODES_W-1:0] codes,
  input  logic [IDX_W-1:0]   combo,
  input  logic [NCOMBO-1:0]  target,
  output logic               f_out,
  output logic               match
);
  logic want;
  always_comb begin
    f_out = net_output(codes, combo);
    want  = target[combo];
    match = (f_out == want);
  end
endmodule

// File: rtl/gg_sweep_ctrl.sv
module gg_sweep_ctrl
  import gg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             match,
  output logic             busy,
  output logic [IDX_W-1:0] combo,
  output logic             done,
  output logic [FIT_W-1:0] fitness
);
  logic             accept;
  logic             last;
  logic [FIT_W-1:0] acc;
  logic [FIT_W-1:0] acc_next;

  assign accept   = start && !busy;
  assign last     = busy && (combo == IDX_W'(NCOMBO - 1));
  assign acc_next = acc + FIT_W'(match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      combo   <= '0;
      acc     <= '0;
      done    <= 1'b0;
      fitness <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      combo <= '0;
      acc   <= '0;
      done  <= 1'b0;
    end else if (busy) begin
      if (last) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        fitness <= acc_next;
      end else begin
        combo <= combo + 1'b1;
        acc   <= acc_next;
      end
    end
  end

  // R5: score bounded by the number of combinations
  assert_fitness_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fitness <= FIT_W'(NCOMBO)));
  // R6: done rises only at the end of a full sweep
  assert_done_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && $past(combo) == IDX_W'(NCOMBO - 1)));
  // R6: result held while idle
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fitness)));
  // R7: a running sweep steps on regardless of start
  assert_sweep_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && combo != IDX_W'(NCOMBO - 1)) |=> (busy && combo == $past(combo) + 1'b1));
endmodule

// File: rtl/gate_grid_fitness.sv
module gate_grid_fitness
  import gg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CODES_W-1:0] codes_in,
  input  logic [NCOMBO-1:0]  target_in,
  input  logic               start,
  output logic               done,
  output logic [FIT_W-1:0]   fitness
);
  logic               busy;
  logic [IDX_W-1:0]   combo;
  logic [CODES_W-1:0] codes_q;
  logic [NCOMBO-1:0]  target_q;
  logic               f_out;
  logic               match;

  gg_code_store u_store (
    .clk(clk), .rst_n(rst_n), .load(load), .busy(busy),
    .codes_in(codes_in), .target_in(target_in),
    .codes_q(codes_q), .target_q(target_q)
  );

  gg_net_eval u_eval (
    .codes(codes_q), .combo(combo), .target(target_q),
    .f_out(f_out), .match(match)
  );

  gg_sweep_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .match(match),
    .busy(busy), .combo(combo), .done(done), .fitness(fitness)
  );

  // R1: no result flagged before a sweep has completed
  assert_idle_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !busy) |=> (!done || $past(busy)));
endmodule

// File: tb/gate_grid_fitness_test.sv
module gate_grid_fitness_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [83:0] codes_in = '0;
  logic [7:0]  target_in = '0;
  logic        start = 1'b0;
  logic        done;
  logic [3:0]  fitness;

  int checks = 0;
  int errors = 0;
  int unsigned seed = 32'h1ACE_5EED;

  always #10 clk = ~clk;   // 50 MHz

  gate_grid_fitness uut (
    .clk(clk), .rst_n(rst_n), .load(load), .codes_in(codes_in),
    .target_in(target_in), .start(start), .done(done), .fitness(fitness)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [83:0] put_row(input logic [83:0] cv, input int r,
                                          input int a, input int g, input int b);
    logic [83:0] v;
    v = cv;
    v[(3*r)*4 +: 4]   = 4'(a);
    v[(3*r+1)*4 +: 4] = 4'(g);
    v[(3*r+2)*4 +: 4] = 4'(b);
    return v;
  endfunction

  // Behavioural interpreter written from the requirements.
  function automatic int model_fit(input logic [83:0] cv, input logic [7:0] tg);
    int score;
    score = 0;
    for (int k = 0; k < 8; k++) begin
      int v[10];
      int f;
      f = 0;
      v[0] = 0;
      v[1] = (k / 4) % 2;
      v[2] = (k / 2) % 2;
      v[3] = k % 2;
      for (int r = 0; r < 7; r++) begin
        int oa, og, ob, x, y, res;
        oa = int'(cv[(3*r)*4 +: 4]);
        og = int'(cv[(3*r+1)*4 +: 4]);
        ob = int'(cv[(3*r+2)*4 +: 4]);
        x = (oa > 0 && oa <= 9 && oa <= r + 3) ? v[oa] : 0;
        y = (ob > 0 && ob <= 9 && ob <= r + 3) ? v[ob] : 0;
        if (og == 1)      res = x * y;
        else if (og == 2) res = (x + y > 0) ? 1 : 0;
        else if (og == 3) res = (x + y) % 2;
        else if (og == 4) res = 1 - x;
        else              res = 0;
        if (r < 6) v[r + 4] = res; else f = res;
      end
      if (f == int'(tg[k])) score++;
    end
    return score;
  endfunction

  function automatic int unsigned next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  // inject: 0 none, 1 start mid-sweep, 2 load mid-sweep with alt codes
  task automatic sweep(input logic [83:0] cv, input logic [7:0] tg,
                       input int inject, input logic [83:0] alt,
                       input bit do_load, input string req);
    bit tim_ok;
    int exp;
    tim_ok = 1'b1;
    if (do_load) begin
      @(negedge clk);
      codes_in = cv; target_in = tg; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
    end else begin
      @(negedge clk);
    end
    start = 1'b1;
    @(negedge clk);             // edge E0 has sampled start
    start = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);           // after edge Ei
      if (i == 3 && inject == 1) start = 1'b1;
      if (i == 3 && inject == 2) begin
        codes_in = alt; target_in = ~tg; load = 1'b1;
      end
      if (i == 4) begin
        start = 1'b0; load = 1'b0;
      end
      if (done != (i == 8)) tim_ok = 1'b0;
    end
    check(tim_ok, "R6 done schedule", int'(done), 1);
    exp = model_fit(cv, tg);
    check(int'(fitness) == exp, req, int'(fitness), exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [83:0] cv;
    logic [83:0] alt;
    logic [3:0]  held;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(done == 1'b0 && fitness == 4'd0, "R1 reset", int'(fitness), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && fitness == 4'd0, "R1 after release", int'(done), 0);

    // R2 R9: difference circuit A^B^C built through R0 and S0 into F
    cv = '0;
    cv = put_row(cv, 0, 1, 3, 2);
    cv = put_row(cv, 3, 4, 3, 3);
    cv = put_row(cv, 6, 7, 2, 0);
    sweep(cv, 8'h96, 0, '0, 1'b1, "R2 R9 xor chain");
    check(fitness == 4'd8, "R5 full match", int'(fitness), 8);
    sweep(cv, 8'h69, 0, '0, 1'b1, "R5 inverted target");
    check(fitness == 4'd0, "R5 zero match", int'(fitness), 0);

    // R6: result holds while idle
    held = fitness;
    repeat (4) @(negedge clk);
    check(done == 1'b1 && fitness == held, "R6 hold", int'(fitness), int'(held));

    // R3: AND, OR, NOT and dead gate codes on the output row
    cv = put_row('0, 6, 1, 1, 2);
    sweep(cv, 8'hC0, 0, '0, 1'b1, "R3 and");
    cv = put_row('0, 6, 3, 2, 2);
    sweep(cv, 8'hFC, 0, '0, 1'b1, "R2 R3 or of C,B");
    cv = put_row('0, 6, 1, 4, 2);
    sweep(cv, 8'h0F, 0, '0, 1'b1, "R3 not ignores second operand");
    check(fitness == 4'd8, "R3 not", int'(fitness), 8);
    cv = put_row('0, 6, 1, 0, 2);
    sweep(cv, 8'h00, 0, '0, 1'b1, "R3 gate code 0");
    check(fitness == 4'd8, "R3 gate 0 gives 0", int'(fitness), 8);
    cv = put_row('0, 6, 1, 9, 2);
    sweep(cv, 8'h00, 0, '0, 1'b1, "R3 gate code 9");
    check(fitness == 4'd8, "R3 gate 9 gives 0", int'(fitness), 8);

    // R4: forward reference, own-net reference and out-of-range operand
    cv = put_row('0, 0, 5, 2, 1);     // R0 = R1(not yet) | A
    cv = put_row(cv, 1, 5, 2, 0);     // R1 = own net -> 0
    cv = put_row(cv, 6, 4, 2, 5);     // F = R0 | R1
    sweep(cv, 8'hF0, 0, '0, 1'b1, "R4 forward and self refs");
    check(fitness == 4'd8, "R4 refs read 0", int'(fitness), 8);
    cv = put_row('0, 6, 12, 2, 1);
    sweep(cv, 8'hF0, 0, '0, 1'b1, "R4 code 12");
    check(fitness == 4'd8, "R4 code 12 reads 0", int'(fitness), 8);

    // R7: start during sweep ignored
    cv = put_row('0, 2, 2, 3, 3);     // R2 = B^C
    cv = put_row(cv, 5, 6, 1, 1);     // S2 = R2 & A
    cv = put_row(cv, 6, 9, 2, 0);
    sweep(cv, 8'h5A, 1, '0, 1'b1, "R7 start mid-sweep");
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R7 no restart", int'(done), 1);

    // R8: load during sweep ignored, old codes reused by next start
    alt = put_row('0, 6, 1, 4, 0);
    sweep(cv, 8'h3C, 2, alt, 1'b1, "R8 load mid-sweep");
    sweep(cv, 8'h3C, 0, '0, 1'b0, "R8 held codes reused");

    // R5 R2 R3 R4 R9: pseudo-random netlists
    for (int n = 0; n < 300; n++) begin
      logic [83:0] rc;
      logic [7:0]  rt;
      rc = '0;
      for (int r = 0; r < 7; r++)
        rc = put_row(rc, r, int'(next_rand() % 12), int'(next_rand() % 6),
                     int'(next_rand() % 12));
      rt = 8'(next_rand());
      sweep(rc, rt, 0, '0, 1'b1, "R5 random netlist");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule